// File: doc/BRIEF.md
# Accumulator Saturation and Rounding Unit

This block sits behind the adder of a multiply-accumulate datapath and decides what is stored in one of two 40-bit signed accumulators. Each cycle the adder offers a 40-bit wrapped sum, its carry out of the top bit and the sign bits of its two operands. From these the block works out the sign of the exact result. Depending on the selected mode, it stores the sum unchanged, clamps it to the 32-bit signed range, or clamps it to the full 40-bit range.

Every accumulator has two sticky flags. One flag records saturation events and the other records results that left the 32-bit range. The block also gives a 16-bit rounded view of the selected accumulator, using either round-half-up or round-half-to-even.

Top module: `acc_sat_round`

## Requirements
- R1: While rst_ni is low, both accumulators, all four flags and rnd_o are zero.
- R2: With sat_mode_i = 0 (and the unused code 3), a write stores sum_i unchanged, so out-of-range results wrap.
- R3: With sat_mode_i = 1, a write whose exact result lies outside [-2^31, 2^31-1] stores 0x007FFFFFFF if the result is positive and 0xFF80000000 if it is negative. Otherwise sum_i is stored.
- R4: With sat_mode_i = 2, a write whose exact result lies outside [-2^39, 2^39-1] stores 0x7FFFFFFFFF if the result is positive and 0x8000000000 if it is negative. Otherwise sum_i is stored.
- R5: The clamp direction follows the exact sign, sign_a_i ^ sign_b_i ^ carry_i, and not bit 39 of sum_i.
- R6: The saturation flag of the written accumulator (sat_a_o for A, sat_b_o for B) is set when the exact result leaves the 40-bit range or when a clamp occurs. It stays set until clr_sat_i (bit 0 for A, bit 1 for B) is asserted. If a set and a clear fall in the same cycle, the set wins.
- R7: The overflow flag (ovf_a_o, ovf_b_o) is set in every mode when the exact result leaves the 32-bit range. It is cleared only by clr_ovf_i (bit 0 for A, bit 1 for B), and a set wins over a clear in the same cycle.
- R8: When rnd_conv_i = 0, rnd_o equals bits 31:16 of (acc + 0x8000). Here acc is the stored accumulator picked by acc_sel_i (0 = A, 1 = B).
- R9: When rnd_conv_i = 1, rnd_o matches R8 except when bits 15:0 of acc equal exactly 0x8000. In that case rnd_o is bits 31:16 of acc, plus one only when bit 16 of acc is 1.
- R10: Without wr_en_i no accumulator or flag is set. With wr_en_i only the accumulator picked by acc_sel_i changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the selected accumulator |
| acc_sel_i | input | 1 | 0 selects A, 1 selects B (write and rounding) |
| sat_mode_i | input | 2 | 0 none, 1 clamp at 32 bits, 2 clamp at 40 bits, 3 none |
| rnd_conv_i | input | 1 | 0 round half up, 1 round half to even |
| sum_i | input | 40 | Wrapped adder sum |
| carry_i | input | 1 | Adder carry out of bit 39 |
| sign_a_i | input | 1 | Sign bit of first adder operand |
| sign_b_i | input | 1 | Sign bit of second adder operand |
| clr_sat_i | input | 2 | Clear saturation flags (bit 0 A, bit 1 B) |
| clr_ovf_i | input | 2 | Clear overflow flags (bit 0 A, bit 1 B) |
| acc_a_o | output | 40 | Accumulator A |
| acc_b_o | output | 40 | Accumulator B |
| sat_a_o | output | 1 | Sticky saturation flag of A |
| sat_b_o | output | 1 | Sticky saturation flag of B |
| ovf_a_o | output | 1 | Sticky 32-bit overflow flag of A |
| ovf_b_o | output | 1 | Sticky 32-bit overflow flag of B |
| rnd_o | output | 16 | Rounded upper word of the selected accumulator |

## Verification
The bench aims at sums that wrap past bit 39, where the sign of sum_i is the opposite of the true sign. A design that clamps on the sum's own sign would load the wrong rail there. It also drives results exactly one step beyond each range limit, where an off-by-one compare would store a wrapped value or clamp a value that is still legal.

Exact 0x8000 ties with both even and odd upper words separate round-half-up from round-half-to-even. A design that skips the tie test would give an odd result.

Clears issued in the same cycle as a new overflow show whether the flags can lose an event. Idle cycles and cycles that target the other accumulator expose writes that leak into the wrong register.

// File: rtl/acc_sat_pkg.sv
package acc_sat_pkg;
  typedef enum logic [1:0] {
    SAT_NONE  = 2'd0,
    SAT_NORM  = 2'd1,
    SAT_SUPER = 2'd2,
    SAT_RSVD  = 2'd3
  } sat_mode_e;
endpackage

// File: rtl/acc_ovf_detect.sv
module acc_ovf_detect #(
  parameter int ACC_W  = 40,
  parameter int NORM_W = 32
) (
  input  logic [ACC_W-1:0] sum_i,
  input  logic             carry_i,
  input  logic             sign_a_i,
  input  logic             sign_b_i,
  output logic             true_neg_o,
  output logic             ovf_full_o,
  output logic             ovf_norm_o
);
  localparam int TOP_W = ACC_W - NORM_W + 1;

  // bit ACC_W of the sign-extended exact sum
  assign true_neg_o = sign_a_i ^ sign_b_i ^ carry_i;
  assign ovf_full_o = sum_i[ACC_W-1] != true_neg_o;
  assign ovf_norm_o = sum_i[ACC_W-1:NORM_W-1] != {TOP_W{true_neg_o}};
endmodule

// File: rtl/acc_sat_clamp.sv
module acc_sat_clamp
  import acc_sat_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int NORM_W = 32
) (
  input  sat_mode_e        mode_i,
  input  logic [ACC_W-1:0] sum_i,
  input  logic             true_neg_i,
  input  logic             ovf_full_i,
  input  logic             ovf_norm_i,
  output logic [ACC_W-1:0] res_o,
  output logic             clamped_o
);
  localparam logic [ACC_W-1:0] NORM_POS  = {{(ACC_W-NORM_W+1){1'b0}}, {(NORM_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NORM_NEG  = ~NORM_POS;
  localparam logic [ACC_W-1:0] SUPER_POS = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] SUPER_NEG = ~SUPER_POS;

  always_comb begin
    res_o     = sum_i;
    clamped_o = 1'b0;
    unique case (mode_i)
      SAT_NORM: if (ovf_norm_i) begin
        res_o     = true_neg_i ? NORM_NEG : NORM_POS;
        clamped_o = 1'b1;
      end
      SAT_SUPER: if (ovf_full_i) begin
        res_o     = true_neg_i ? SUPER_NEG : SUPER_POS;
        clamped_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_round.sv
module acc_round #(
  parameter int ACC_W = 40,
  parameter int RND_W = 16
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic             conv_i,
  output logic [RND_W-1:0] rnd_o
);
  localparam logic [ACC_W-1:0] HALF     = ACC_W'(1) << (RND_W - 1);
  localparam logic [RND_W-1:0] HALF_LOW = {1'b1, {(RND_W-1){1'b0}}};

  logic [ACC_W-1:0] bumped;
  logic             tie;

  assign bumped = acc_i + HALF;
  assign tie    = acc_i[RND_W-1:0] == HALF_LOW;

  always_comb begin
    // even upper word on a tie: keep it, odd upper word: carry makes it even
    if (conv_i && tie && !acc_i[RND_W]) rnd_o = acc_i[2*RND_W-1:RND_W];
    else                                rnd_o = bumped[2*RND_W-1:RND_W];
  end

  always_comb begin
    // R9
    if (conv_i && tie) tie_even_chk: assert (rnd_o[0] == 1'b0);
    // R8
    if (!acc_i[RND_W-1]) trunc_chk: assert (rnd_o == acc_i[2*RND_W-1:RND_W]);
  end
endmodule

// File: rtl/acc_sat_round.sv
module acc_sat_round
  import acc_sat_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int NORM_W = 32,
  parameter int RND_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             acc_sel_i,
  input  logic [1:0]       sat_mode_i,
  input  logic             rnd_conv_i,
  input  logic [ACC_W-1:0] sum_i,
  input  logic             carry_i,
  input  logic             sign_a_i,
  input  logic             sign_b_i,
  input  logic [1:0]       clr_sat_i,
  input  logic [1:0]       clr_ovf_i,
  output logic [ACC_W-1:0] acc_a_o,
  output logic [ACC_W-1:0] acc_b_o,
  output logic             sat_a_o,
  output logic             sat_b_o,
  output logic             ovf_a_o,
  output logic             ovf_b_o,
  output logic [RND_W-1:0] rnd_o
);
  localparam int NUM_ACC = 2;
  localparam logic [ACC_W-1:0] SUPER_POS = {1'b0, {(ACC_W-1){1'b1}}};

  logic             true_neg, ovf_full, ovf_norm, clamped;
  logic [ACC_W-1:0] res;
  logic [ACC_W-1:0] acc_q [NUM_ACC];
  logic [NUM_ACC-1:0] sat_q, ovf_q;

  acc_ovf_detect #(.ACC_W(ACC_W), .NORM_W(NORM_W)) u_det (
    .sum_i      (sum_i),
    .carry_i    (carry_i),
    .sign_a_i   (sign_a_i),
    .sign_b_i   (sign_b_i),
    .true_neg_o (true_neg),
    .ovf_full_o (ovf_full),
    .ovf_norm_o (ovf_norm)
  );

  acc_sat_clamp #(.ACC_W(ACC_W), .NORM_W(NORM_W)) u_clamp (
    .mode_i     (sat_mode_e'(sat_mode_i)),
    .sum_i      (sum_i),
    .true_neg_i (true_neg),
    .ovf_full_i (ovf_full),
    .ovf_norm_i (ovf_norm),
    .res_o      (res),
    .clamped_o  (clamped)
  );

  for (genvar i = 0; i < NUM_ACC; i++) begin : gen_acc
    logic hit;
    assign hit = wr_en_i && (acc_sel_i == 1'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_q[i] <= '0;
        sat_q[i] <= 1'b0;
        ovf_q[i] <= 1'b0;
      end else begin
        if (hit) acc_q[i] <= res;
        // set has priority over clear so no event is lost
        if (hit && (ovf_full || clamped)) sat_q[i] <= 1'b1;
        else if (clr_sat_i[i])            sat_q[i] <= 1'b0;
        if (hit && ovf_norm)              ovf_q[i] <= 1'b1;
        else if (clr_ovf_i[i])            ovf_q[i] <= 1'b0;
      end
    end
  end

  assign acc_a_o = acc_q[0];
  assign acc_b_o = acc_q[1];
  assign sat_a_o = sat_q[0];
  assign sat_b_o = sat_q[1];
  assign ovf_a_o = ovf_q[0];
  assign ovf_b_o = ovf_q[1];

  acc_round #(.ACC_W(ACC_W), .RND_W(RND_W)) u_rnd (
    .acc_i  (acc_sel_i ? acc_q[1] : acc_q[0]),
    .conv_i (rnd_conv_i),
    .rnd_o  (rnd_o)
  );

  // R2
  no_sat_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !acc_sel_i && (sat_mode_i == 2'd0 || sat_mode_i == 2'd3))
    |=> acc_a_o == $past(sum_i));

  // R3
  norm_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !acc_sel_i && sat_mode_i == 2'd1)
    |=> (acc_a_o[ACC_W-1:NORM_W-1] == '0 || acc_a_o[ACC_W-1:NORM_W-1] == '1));

  // R4
  super_rail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !acc_sel_i && sat_mode_i == 2'd2 && ovf_full)
    |=> acc_a_o == ($past(true_neg) ? ~SUPER_POS : SUPER_POS));

  // R6
  sat_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_a_o && !clr_sat_i[0]) |=> sat_a_o);

  // R7
  ovf_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_a_o) |-> $past(wr_en_i && !acc_sel_i));

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(acc_a_o) && $stable(acc_b_o)));
endmodule

// File: tb/acc_sat_round_bench.sv
module acc_sat_round_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0, acc_sel = 1'b0, rnd_conv = 1'b0;
  logic [1:0]  sat_mode = 2'd0, clr_sat = 2'd0, clr_ovf = 2'd0;
  logic [39:0] sum = '0;
  logic        carry = 1'b0, sgn_a = 1'b0, sgn_b = 1'b0;
  logic [39:0] acc_a, acc_b;
  logic        sat_a, sat_b, ovf_a, ovf_b;
  logic [15:0] rnd;

  logic [39:0] op_a = '0, op_b = '0;
  logic [39:0] m_acc [2];
  logic [1:0]  m_sat, m_ovf;
  string       acc_tag = "R1";
  int          n_tests = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  acc_sat_round u_acc_sat_round (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .acc_sel_i(acc_sel),
    .sat_mode_i(sat_mode), .rnd_conv_i(rnd_conv), .sum_i(sum), .carry_i(carry),
    .sign_a_i(sgn_a), .sign_b_i(sgn_b), .clr_sat_i(clr_sat), .clr_ovf_i(clr_ovf),
    .acc_a_o(acc_a), .acc_b_o(acc_b), .sat_a_o(sat_a), .sat_b_o(sat_b),
    .ovf_a_o(ovf_a), .ovf_b_o(ovf_b), .rnd_o(rnd)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_acc[0] <= '0; m_acc[1] <= '0; m_sat <= '0; m_ovf <= '0;
    end else begin
      longint ex;
      bit out32, out40, clamp;
      logic [39:0] nv;
      int k;
      ex    = longint'($signed(op_a)) + longint'($signed(op_b));
      out32 = (ex > 64'sd2147483647) || (ex < -64'sd2147483648);
      out40 = (ex > 64'sd549755813887) || (ex < -64'sd549755813888);
      clamp = 1'b0;
      nv    = ex[39:0];
      if (sat_mode == 2'd1 && out32) begin
        nv = (ex < 0) ? 40'hFF8000_0000 : 40'h007FFF_FFFF; clamp = 1'b1;
      end else if (sat_mode == 2'd2 && out40) begin
        nv = (ex < 0) ? 40'h8000_000000 : 40'h7FFF_FFFFFF; clamp = 1'b1;
      end
      k = acc_sel ? 1 : 0;
      for (int i = 0; i < 2; i++) begin
        if (wr_en && k == i) m_acc[i] <= nv;
        if (wr_en && k == i && (out40 || clamp)) m_sat[i] <= 1'b1;
        else if (clr_sat[i]) m_sat[i] <= 1'b0;
        if (wr_en && k == i && out32) m_ovf[i] <= 1'b1;
        else if (clr_ovf[i]) m_ovf[i] <= 1'b0;
      end
    end
  end

  function automatic logic [15:0] ref_rnd(logic [39:0] v, logic conv);
    longint s, r;
    s = longint'($signed(v));
    if (conv && (s & 64'hFFFF) == 64'h8000 && ((s >>> 16) & 1) == 0) r = s >>> 16;
    else r = (s + 64'sd32768) >>> 16;
    return r[15:0];
  endfunction

  task automatic chk(string tag, string what, logic [39:0] act, logic [39:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    chk(acc_tag, "acc_a", acc_a, m_acc[0]);
    chk(acc_tag, "acc_b", acc_b, m_acc[1]);
    chk("R6", "sat_a", 40'(sat_a), 40'(m_sat[0]));
    chk("R6", "sat_b", 40'(sat_b), 40'(m_sat[1]));
    chk("R7", "ovf_a", 40'(ovf_a), 40'(m_ovf[0]));
    chk("R7", "ovf_b", 40'(ovf_b), 40'(m_ovf[1]));
    chk(rnd_conv ? "R9" : "R8", "rnd", 40'(rnd),
        40'(ref_rnd(acc_sel ? m_acc[1] : m_acc[0], rnd_conv)));
  endtask

  task automatic drive(logic we, logic sel, logic [1:0] md, logic cv,
                       logic [39:0] a, logic [39:0] b, logic [1:0] cs, logic [1:0] co);
    logic [40:0] w;
    w = {1'b0, a} + {1'b0, b};
    wr_en = we; acc_sel = sel; sat_mode = md; rnd_conv = cv;
    op_a = a; op_b = b; sum = w[39:0]; carry = w[40];
    sgn_a = a[39]; sgn_b = b[39]; clr_sat = cs; clr_ovf = co;
    if (!we) acc_tag = "R10";
    else case (md)
      2'd1: acc_tag = "R3";
      2'd2: acc_tag = "R4";
      default: acc_tag = "R2";
    endcase
  endtask

  // one cycle: check settled outputs, then apply next stimulus
  task automatic step(logic we, logic sel, logic [1:0] md, logic cv,
                      logic [39:0] a, logic [39:0] b, logic [1:0] cs, logic [1:0] co);
    @(negedge clk);
    check_all();
    drive(we, sel, md, cv, a, b, cs, co);
  endtask

  function automatic logic [39:0] rnd_op();
    logic [63:0] r;
    r = {$urandom, $urandom};
    case ($urandom % 4)
      0: return 40'($signed(r[15:0]));
      1: return 40'($signed(r[31:0]));
      2: return 40'($signed(r[35:0]));
      default: return r[39:0];
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: outputs cleared during reset
    chk("R1", "acc_a rst", acc_a, '0);
    chk("R1", "acc_b rst", acc_b, '0);
    chk("R1", "flags rst", 40'({sat_a, sat_b, ovf_a, ovf_b}), '0);
    chk("R1", "rnd rst", 40'(rnd), '0);
    rst_ni = 1'b1;
    // R2: wrap in none mode, A
    step(1, 0, 2'd0, 0, 40'h007FFFFFFF, 40'h1, 0, 0);
    // R3: positive clamp just past 32-bit limit
    step(1, 0, 2'd1, 0, 40'h007FFFFFFF, 40'h1, 0, 0);
    // R3: negative clamp just past limit, B
    step(1, 1, 2'd1, 0, 40'hFF80000000, 40'hFFFFFFFFFF, 0, 0);
    // R3: exactly at limit, no clamp
    step(1, 1, 2'd1, 0, 40'h007FFFFFFE, 40'h1, 0, 0);
    // R5: sum wraps past bit 39, true sign positive, normal mode
    step(1, 0, 2'd1, 0, 40'h7FFFFFFFFF, 40'h7FFFFFFFFF, 0, 0);
    // R5: wrap negative in super mode
    step(1, 0, 2'd2, 0, 40'h8000000000, 40'h8000000000, 0, 0);
    // R4: positive super clamp, B
    step(1, 1, 2'd2, 0, 40'h7FFFFFFFFF, 40'h1, 0, 0);
    // R4: large but legal, no clamp
    step(1, 1, 2'd2, 0, 40'h7FFFFFFFFE, 40'h1, 0, 0);
    // R2: mode 3 wraps, sets sat via 40-bit overflow
    step(1, 0, 2'd3, 0, 40'h7FFFFFFFFF, 40'h1, 0, 0);
    // R6 R7: set and clear same cycle, set wins
    step(1, 0, 2'd0, 0, 40'h7FFFFFFFFF, 40'h1, 2'b11, 2'b11);
    // R6 R7: clear alone
    step(0, 0, 2'd0, 0, 0, 0, 2'b11, 2'b11);
    // R9: tie with even upper word stays
    step(1, 0, 2'd0, 1, 40'h0000048000, 40'h0, 0, 0);
    step(0, 0, 2'd0, 1, 0, 0, 0, 0);
    // R9: tie with odd upper word rounds up
    step(1, 0, 2'd0, 1, 40'h0000058000, 40'h0, 0, 0);
    step(0, 0, 2'd0, 0, 0, 0, 0, 0);
    // R8: tie under conventional rounding rounds up
    step(1, 1, 2'd0, 0, 40'h0000048000, 40'h0, 0, 0);
    step(0, 1, 2'd0, 0, 0, 0, 0, 0);
    // R8: negative value just below tie
    step(1, 1, 2'd0, 0, 40'hFFFFFF7FFF, 40'h0, 0, 0);
    // R10: idle cycles
    step(0, 0, 2'd1, 0, 40'h7FFFFFFFFF, 40'h7FFFFFFFFF, 0, 0);
    step(0, 1, 2'd2, 1, 40'h8000000000, 40'h8000000000, 0, 0);
    for (int n = 0; n < 4000; n++) begin
      logic [39:0] a, b;
      a = rnd_op();
      b = rnd_op();
      if ($urandom % 8 == 0) b = {$urandom, $urandom} & 40'hFFFF_FFFF_FF;
      if ($urandom % 6 == 0) begin a = {a[39:16], 16'h8000}; b = '0; end
      step(($urandom % 4) != 0, 1'($urandom), 2'($urandom), 1'($urandom), a, b,
           ($urandom % 16 == 0) ? 2'($urandom) : 2'b00,
           ($urandom % 16 == 0) ? 2'($urandom) : 2'b00);
    end
    @(negedge clk);
    check_all();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule